// File: doc/BRIEF.md
# Non-Coherent Preamble Synchronizer and Half-Symbol Energy Detector

This block sits behind an integrate-and-dump converter in an impulse-radio receiver. Each accepted input sample is an unsigned 6-bit energy value covering 16 ns. The square-law front end removes pulse polarity, so the block matches the sample stream against the magnitude pattern of the known ternary preamble code. That pattern has a one for every nonzero code element and a zero elsewhere. Each code element spans two samples.

Two correlators watch the same 62-sample window, one sample apart. Both are evaluated on every second accepted sample. A score above a programmable threshold is a candidate timing hit. The same evaluation point must repeat the hit in consecutive preamble periods before lock is declared. The correlator with the higher score at that moment fixes the symbol phase to one sample.

After lock, every 64 samples form one burst-position symbol. The block sums the energy of each half-symbol and emits one decided bit, with a pulse and a running count. A synchronous clear input returns the block to its search state.

Top module: `ned_sync_detector`

## Requirements
- R1: After reset, `locked`, `bitValid`, `bitOut` and `bitCount` are all zero.
- R2: The early score is the sum of the samples at even delays 2k (the newest sample has delay 0), taken for each k whose code element CODE_MASK[CODE_LEN-1-k] is nonzero. A negative code element counts the same as a positive one. The late score uses the same taps one sample older (delay 2k+1). Both scores are evaluated only on accepted samples whose sample-phase count since clear is odd. The sample-phase count runs 0..61.
- R3: An evaluation point is a hit when either score is strictly greater than `threshold`. A score equal to the threshold is not a hit.
- R4: Lock is declared on the third hit at the same sample phase in three consecutive 62-sample periods. The first hit while no candidate is held sets the candidate phase. A non-hit at the candidate phase discards the candidate. `locked` then stays high until clear.
- R5: At the locking sample, the late score may be strictly higher than the early score. In that case the next accepted sample is index 1 of the first symbol. Otherwise the next accepted sample is index 0.
- R6: A symbol is 64 accepted samples. Indices 0..31 are summed into the first half and 32..63 into the second half. The decided bit is 1 when the first-half sum is greater than the second-half sum.
- R7: Equal half-symbol sums decide 0.
- R8: On the clock edge that accepts symbol index 63, `bitValid` goes high for one cycle with the bit on `bitOut`. `bitCount` increments on that same edge and wraps at its width. `bitOut` holds its value between decisions.
- R9: A high `clear` on a clock edge drops lock, empties the sample window, and zeroes the phase, candidate, symbol and bit counters and the outputs.
- R10: A cycle with `sampleValid` low and `clear` low changes no state and no output (except `bitValid` returning low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous return to search state |
| sampleValid | input | 1 | Qualifies `sample` for one cycle |
| sample | input | SAMPLE_W | Unsigned integrated-energy sample |
| threshold | input | CORR_W | Hit threshold, compared strictly greater |
| locked | output | 1 | Timing lock achieved |
| bitValid | output | 1 | One-cycle strobe for a decided bit |
| bitOut | output | 1 | Most recent decided bit |
| bitCount | output | CNT_W | Count of decided bits |

## Verification
The hardest situation to reach from the ports is deciding which correlator wins, because the late score is simply the early score one sample later. The stimulus therefore places the preamble pulses at both sample parities. A one-sample lead-in puts the peak on the early correlator. No lead-in puts it on the late correlator.

Both cases must then decode the same data at the same port timing. The miss-and-restart path is driven by a blank period between good ones. The strict threshold edge is driven with noise-free preambles, using the exact peak value as the threshold and then one below it.

// File: rtl/ned_pkg.sv
`timescale 1ns/1ps
package ned_pkg;
  // Strobes from the control FSM to the datapath, one sample at a time.
  typedef struct packed {
    logic shift;      // accept the current sample into the window
    logic wipe;       // empty window and accumulators
    logic addFirst;   // add sample to first-half energy
    logic addSecond;  // add sample to second-half energy
    logic dump;       // zero both half accumulators
  } ned_strobe_t;
endpackage

// File: rtl/ned_correlator.sv
`timescale 1ns/1ps
module ned_correlator #(
  parameter int SAMPLE_W = 6,
  parameter int CODE_LEN = 31,
  parameter logic [CODE_LEN-1:0] CODE_MASK = '1,
  parameter int LAG = 0,
  parameter int WIN_LEN = 2 * CODE_LEN,
  parameter int CORR_W = 11
) (
  input  logic [WIN_LEN*SAMPLE_W-1:0] taps,
  output logic [CORR_W-1:0]           score
);
  // Tap k looks at delay 2k+LAG and belongs to element CODE_LEN-1-k.
  always_comb begin
    score = '0;
    for (int k = 0; k < CODE_LEN; k++) begin
      if (CODE_MASK[CODE_LEN-1-k])
        score = score + CORR_W'(taps[(2*k+LAG)*SAMPLE_W +: SAMPLE_W]);
    end
  end
endmodule

// File: rtl/ned_datapath.sv
`timescale 1ns/1ps
module ned_datapath
  import ned_pkg::*;
#(
  parameter int SAMPLE_W = 6,
  parameter int CODE_LEN = 31,
  parameter logic [CODE_LEN-1:0] CODE_MASK = '1,
  parameter int SYM_LEN = 64,
  parameter int CORR_W = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ned_strobe_t         stb,
  input  logic [SAMPLE_W-1:0] sample,
  output logic [CORR_W-1:0]   scoreEarly,
  output logic [CORR_W-1:0]   scoreLate,
  output logic                firstWins
);
  localparam int WIN_LEN = 2 * CODE_LEN;
  localparam int HALF    = SYM_LEN / 2;
  localparam int ACC_W   = $clog2(HALF * ((1 << SAMPLE_W) - 1) + 1);

  logic [SAMPLE_W-1:0] win [WIN_LEN];
  logic [WIN_LEN*SAMPLE_W-1:0] winNext;
  logic [ACC_W-1:0] accFirst, accSecond;
  logic [CORR_W-1:0] scores [2];

  // Window including the sample on the input this cycle.
  assign winNext[SAMPLE_W-1:0] = sample;
  for (genvar g = 1; g < WIN_LEN; g++) begin : g_flat
    assign winNext[g*SAMPLE_W +: SAMPLE_W] = win[g-1];
  end

  for (genvar c = 0; c < 2; c++) begin : g_corr
    ned_correlator #(
      .SAMPLE_W(SAMPLE_W), .CODE_LEN(CODE_LEN), .CODE_MASK(CODE_MASK),
      .LAG(c), .WIN_LEN(WIN_LEN), .CORR_W(CORR_W)
    ) u_corr (
      .taps(winNext),
      .score(scores[c])
    );
  end
  assign scoreEarly = scores[0];
  assign scoreLate  = scores[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN_LEN; i++) win[i] <= '0;
    end else if (stb.wipe) begin
      for (int i = 0; i < WIN_LEN; i++) win[i] <= '0;
    end else if (stb.shift) begin
      win[0] <= sample;
      for (int i = 1; i < WIN_LEN; i++) win[i] <= win[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accFirst  <= '0;
      accSecond <= '0;
    end else if (stb.wipe || stb.dump) begin
      accFirst  <= '0;
      accSecond <= '0;
    end else begin
      if (stb.addFirst)  accFirst  <= accFirst  + ACC_W'(sample);
      if (stb.addSecond) accSecond <= accSecond + ACC_W'(sample);
    end
  end

  // Second half still lacks the sample arriving at symbol end.
  assign firstWins = (ACC_W+1)'(accFirst) >
                     ((ACC_W+1)'(accSecond) + (ACC_W+1)'(sample));
endmodule

// File: rtl/ned_control.sv
`timescale 1ns/1ps
module ned_control
  import ned_pkg::*;
#(
  parameter int CODE_LEN = 31,
  parameter int SYM_LEN = 64,
  parameter int LOCK_HITS = 3,
  parameter int CNT_W = 16,
  parameter int CORR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sampleValid,
  input  logic [CORR_W-1:0] threshold,
  input  logic [CORR_W-1:0] scoreEarly,
  input  logic [CORR_W-1:0] scoreLate,
  input  logic              firstWins,
  output ned_strobe_t       stb,
  output logic              locked,
  output logic              bitValid,
  output logic              bitOut,
  output logic [CNT_W-1:0]  bitCount
);
  localparam int WIN_LEN = 2 * CODE_LEN;
  localparam int HALF    = SYM_LEN / 2;
  localparam int PH_W    = $clog2(WIN_LEN);
  localparam int IDX_W   = $clog2(SYM_LEN);
  localparam int HIT_W   = $clog2(LOCK_HITS + 1);

  logic [PH_W-1:0]  phase, candPhase;
  logic             cand;
  logic [HIT_W-1:0] hits;
  logic [IDX_W-1:0] symIdx;

  logic accept, evalPt, hit, atCand, lockNow, symEnd;

  always_comb begin
    accept  = sampleValid && !clear;
    evalPt  = accept && phase[0];
    hit     = (scoreEarly > threshold) || (scoreLate > threshold);
    atCand  = cand && (phase == candPhase);
    lockNow = !locked && evalPt && atCand && hit &&
              (hits == HIT_W'(LOCK_HITS - 1));
    symEnd  = accept && locked && (symIdx == IDX_W'(SYM_LEN - 1));

    stb.wipe      = clear;
    stb.shift     = accept;
    stb.addFirst  = accept && locked && !symEnd && (symIdx <  IDX_W'(HALF));
    stb.addSecond = accept && locked && !symEnd && (symIdx >= IDX_W'(HALF));
    stb.dump      = symEnd || lockNow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0; candPhase <= '0; cand <= 1'b0; hits <= '0;
      locked <= 1'b0; symIdx <= '0;
      bitValid <= 1'b0; bitOut <= 1'b0; bitCount <= '0;
    end else if (clear) begin
      phase <= '0; candPhase <= '0; cand <= 1'b0; hits <= '0;
      locked <= 1'b0; symIdx <= '0;
      bitValid <= 1'b0; bitOut <= 1'b0; bitCount <= '0;
    end else begin
      bitValid <= 1'b0;
      if (accept) begin
        phase <= (phase == PH_W'(WIN_LEN - 1)) ? '0 : phase + 1'b1;
        if (!locked) begin
          if (evalPt) begin
            if (!cand) begin
              if (hit) begin
                cand      <= 1'b1;
                candPhase <= phase;
                hits      <= HIT_W'(1);
              end
            end else if (atCand) begin
              if (lockNow) begin
                locked <= 1'b1;
                cand   <= 1'b0;
                hits   <= '0;
                symIdx <= (scoreLate > scoreEarly) ? IDX_W'(1) : '0;
              end else if (hit) begin
                hits <= hits + 1'b1;
              end else begin
                cand <= 1'b0;
                hits <= '0;
              end
            end
          end
        end else if (symEnd) begin
          bitOut   <= firstWins;
          bitValid <= 1'b1;
          bitCount <= bitCount + 1'b1;
          symIdx   <= '0;
        end else begin
          symIdx <= symIdx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ned_sync_detector.sv
`timescale 1ns/1ps
module ned_sync_detector
  import ned_pkg::*;
#(
  parameter int SAMPLE_W = 6,
  parameter int CODE_LEN = 31,
  parameter logic [CODE_LEN-1:0] CODE_MASK = 31'b1010111000110110100100001111011,
  parameter int SYM_LEN = 64,
  parameter int LOCK_HITS = 3,
  parameter int CNT_W = 16,
  localparam int CORR_W = $clog2(CODE_LEN * ((1 << SAMPLE_W) - 1) + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [CORR_W-1:0]   threshold,
  output logic                locked,
  output logic                bitValid,
  output logic                bitOut,
  output logic [CNT_W-1:0]    bitCount
);
  ned_strobe_t       stb;
  logic [CORR_W-1:0] scoreEarly, scoreLate;
  logic              firstWins;

  ned_datapath #(
    .SAMPLE_W(SAMPLE_W), .CODE_LEN(CODE_LEN), .CODE_MASK(CODE_MASK),
    .SYM_LEN(SYM_LEN), .CORR_W(CORR_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .sample(sample),
    .scoreEarly(scoreEarly), .scoreLate(scoreLate), .firstWins(firstWins)
  );

  ned_control #(
    .CODE_LEN(CODE_LEN), .SYM_LEN(SYM_LEN), .LOCK_HITS(LOCK_HITS),
    .CNT_W(CNT_W), .CORR_W(CORR_W)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .clear(clear), .sampleValid(sampleValid),
    .threshold(threshold), .scoreEarly(scoreEarly), .scoreLate(scoreLate),
    .firstWins(firstWins), .stb(stb), .locked(locked), .bitValid(bitValid),
    .bitOut(bitOut), .bitCount(bitCount)
  );
endmodule

// File: rtl/ned_checker.sv
`timescale 1ns/1ps
module ned_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             sampleValid,
  input logic             locked,
  input logic             bitValid,
  input logic [CNT_W-1:0] bitCount
);
  // R8: decisions are at least a symbol apart, never back to back
  p_single_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bitValid |=> !bitValid);

  // R8: each decision advances the count by one
  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bitValid |-> bitCount == CNT_W'($past(bitCount) + 1'b1));

  // R8: without a decision or clear the count holds
  p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bitValid && !$past(clear)) |-> bitCount == $past(bitCount));

  // R9: clear returns to search state
  p_clear_search_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!locked && !bitValid && bitCount == '0));

  // R4: lock only rises on an accepted sample
  p_lock_on_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(sampleValid) && !$past(clear)));

  // R4: lock persists until clear
  p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !clear) |=> locked);

  // R6: bits are only decided while locked
  p_bit_needs_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bitValid |-> locked);
endmodule

bind ned_sync_detector ned_checker #(.CNT_W(CNT_W)) u_ned_checker (
  .clk(clk), .rst_n(rst_n), .clear(clear), .sampleValid(sampleValid),
  .locked(locked), .bitValid(bitValid), .bitCount(bitCount)
);

// File: tb/ned_sync_detector_bench.sv
`timescale 1ns/1ps
module ned_sync_detector_bench;
  localparam int SW = 6;
  localparam int CL = 31;
  localparam logic [CL-1:0] MASK = 31'b1010111000110110100100001111011;
  localparam int WL = 2 * CL;
  localparam int SYM = 64;
  localparam int CW = $clog2(CL * 63 + 1);
  localparam int CNTW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic sampleValid = 1'b0;
  logic [SW-1:0] sample = '0;
  logic [CW-1:0] threshold = '0;
  logic locked, bitValid, bitOut;
  logic [CNTW-1:0] bitCount;

  ned_sync_detector #(.SAMPLE_W(SW), .CODE_LEN(CL), .CODE_MASK(MASK),
    .SYM_LEN(SYM), .LOCK_HITS(3), .CNT_W(CNTW)) u_ned_sync_detector (
    .clk(clk), .rst_n(rst_n), .clear(clear), .sampleValid(sampleValid),
    .sample(sample), .threshold(threshold), .locked(locked),
    .bitValid(bitValid), .bitOut(bitOut), .bitCount(bitCount));

  always #2.5 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit seenBits[$];
  int lfsr = 32'h1ace;

  // behavioural reference state
  int mWin[WL];
  int mPh, mCandPh, mHits, mIdx, mAccF, mAccS, mCount;
  bit mCand, mLocked, mBitValid, mBitOut;

  task automatic modelClear();
    for (int i = 0; i < WL; i++) mWin[i] = 0;
    mPh = 0; mCandPh = 0; mHits = 0; mIdx = 0; mAccF = 0; mAccS = 0;
    mCount = 0; mCand = 0; mLocked = 0; mBitValid = 0; mBitOut = 0;
  endtask

  task automatic modelStep(input bit v, input int s, input bit c);
    int a, b;
    bit hit;
    if (c) begin modelClear(); return; end
    mBitValid = 0;
    if (!v) return;
    for (int k = WL - 1; k > 0; k--) mWin[k] = mWin[k-1];
    mWin[0] = s;
    a = 0; b = 0;
    for (int k = 0; k < CL; k++)
      if (MASK[CL-1-k]) begin a += mWin[2*k]; b += mWin[2*k+1]; end
    if (!mLocked) begin
      if (mPh % 2 == 1) begin
        hit = (a > int'(threshold)) || (b > int'(threshold));
        if (!mCand) begin
          if (hit) begin mCand = 1; mCandPh = mPh; mHits = 1; end
        end else if (mPh == mCandPh) begin
          if (hit) begin
            if (mHits == 2) begin
              mLocked = 1; mCand = 0; mHits = 0;
              mIdx = (b > a) ? 1 : 0; mAccF = 0; mAccS = 0;
            end else mHits++;
          end else begin mCand = 0; mHits = 0; end
        end
      end
    end else begin
      if (mIdx == SYM - 1) begin
        mBitOut = (mAccF > mAccS + s); mBitValid = 1;
        mCount = (mCount + 1) % (1 << CNTW);
        mAccF = 0; mAccS = 0; mIdx = 0;
      end else begin
        if (mIdx < SYM / 2) mAccF += s; else mAccS += s;
        mIdx++;
      end
    end
    mPh = (mPh + 1) % WL;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input bit v, input int s, input bit c);
    bit bad;
    @(negedge clk);
    sampleValid = v; sample = SW'(s); clear = c;
    modelStep(v, s, c);
    @(posedge clk);
    #1;
    vectors++;
    bad = 0;
    if (locked !== mLocked) begin bad = 1;
      $display("FAIL R4 locked: actual %0d expected %0d", locked, mLocked); end
    if (bitValid !== mBitValid) begin bad = 1;
      $display("FAIL R8 bitValid: actual %0d expected %0d", bitValid, mBitValid); end
    if (bitOut !== mBitOut) begin bad = 1;
      $display("FAIL R6 bitOut: actual %0d expected %0d", bitOut, mBitOut); end
    if (int'(bitCount) != mCount) begin bad = 1;
      $display("FAIL R8 bitCount: actual %0d expected %0d", bitCount, mCount); end
    if (bad) miscompares++;
    if (bitValid === 1'b1) seenBits.push_back(bitOut);
  endtask

  function automatic int noiseBit(input bit on);
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hb400 : 0);
    return on ? (lfsr & 1) : 0;
  endfunction

  task automatic sendSample(input int s);
    tick(1, s, 0);
    tick(0, 0, 0);
    tick(0, 0, 0);
  endtask

  task automatic sendPeriod(input bit present, input bit noisy);
    for (int i = 0; i < CL; i++) begin
      if (present && MASK[i]) sendSample(63); else sendSample(noiseBit(noisy));
      sendSample(noiseBit(noisy));
    end
  endtask

  // kind: 1 = burst early, 0 = burst late, 2 = flat (equal halves)
  task automatic sendSymbol(input int kind, input bit skipFirst);
    for (int j = 0; j < SYM; j++) begin
      if (skipFirst && j == 0) continue;
      if (kind == 2) sendSample(5);
      else if (kind == 1 && j >= 8 && j < 24) sendSample(30);
      else if (kind == 0 && j >= 40 && j < 56) sendSample(30);
      else sendSample(0);
    end
  endtask

  task automatic doClear();
    tick(1, 0, 1);
    seenBits.delete();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int ones;
    int kinds[6];
    ones = $countones(MASK);
    modelClear();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 locked", int'(locked), 0);
    chk("R1 bitValid", int'(bitValid), 0);
    chk("R1 bitOut", int'(bitOut), 0);
    chk("R1 bitCount", int'(bitCount), 0);

    // R3: a peak exactly equal to the threshold is not a hit
    threshold = CW'(63 * ones);
    doClear();
    sendSample(0);
    repeat (3) sendPeriod(1, 0);
    chk("R3 equal score no lock", int'(locked), 0);
    // R3: one below the peak locks
    threshold = CW'(63 * ones - 1);
    doClear();
    sendSample(0);
    repeat (3) sendPeriod(1, 0);
    chk("R3 score above threshold locks", int'(locked), 1);

    // R2/R5: early-correlator peak (one-sample lead-in), noisy preamble
    threshold = CW'(63 * ones - 16);
    doClear();
    sendSample(0);
    sendPeriod(1, 1); sendPeriod(1, 1);
    chk("R4 not locked after two periods", int'(locked), 0);
    sendPeriod(1, 1);
    chk("R4 locked after third period", int'(locked), 1);
    kinds = '{1, 0, 1, 1, 0, 2};
    for (int n = 0; n < 6; n++) sendSymbol(kinds[n], n == 0);
    chk("R8 bit count early path", int'(bitCount), 6);
    chk("R6 bits seen early path", seenBits.size(), 6);
    for (int n = 0; n < 6 && n < seenBits.size(); n++)
      chk(n == 5 ? "R7 tie decides 0" : "R5 R6 bit early path",
          int'(seenBits[n]), kinds[n] == 1 ? 1 : 0);

    // R10: idle cycles change nothing
    repeat (20) tick(0, 0, 0);
    chk("R10 count held while idle", int'(bitCount), 6);
    chk("R10 lock held while idle", int'(locked), 1);

    // R9: clear drops everything
    doClear();
    chk("R9 lock cleared", int'(locked), 0);
    chk("R9 count cleared", int'(bitCount), 0);

    // R2/R5: late-correlator peak (no lead-in)
    sendPeriod(1, 1); sendPeriod(1, 1); sendPeriod(1, 1);
    chk("R5 locked late path", int'(locked), 1);
    kinds = '{0, 1, 0, 0, 1, 1};
    for (int n = 0; n < 6; n++) sendSymbol(kinds[n], n == 0);
    chk("R8 bit count late path", int'(bitCount), 6);
    for (int n = 0; n < 6 && n < seenBits.size(); n++)
      chk("R5 R6 bit late path", int'(seenBits[n]), kinds[n]);

    // R4: a blank period discards the candidate
    doClear();
    sendSample(0);
    sendPeriod(1, 1); sendPeriod(1, 1); sendPeriod(0, 1);
    sendPeriod(1, 1); sendPeriod(1, 1);
    chk("R4 miss restarts count", int'(locked), 0);
    sendPeriod(1, 1);
    chk("R4 lock after restart", int'(locked), 1);

    repeat (5) tick(0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule